// File: doc/BRIEF.md
# Trap Return Status Sequencer

This block carries out the two trap-return operations of a hart that has a machine level, a supervisor level and an optional hypervisor layer. The pipeline presents a request for a machine return or a supervisor return, together with the current privilege level, the virtualization flag, the relevant status and hypervisor-status bits, and the two saved exception PCs. The block first decides whether the return is allowed. It then registers either a complete result or an exception code. A complete result holds the next status bits, the next privilege, the next virtualization flag, the return PC and a one-cycle request to swap the guest register bank.

Results appear one clock after the request. Requests may arrive on consecutive cycles. Between requests, the registered state outputs keep their last value, so the surrounding core can treat them as its architectural copy.

Privilege encoding used throughout: user 0, supervisor 1, machine 3. Exception codes: misaligned fetch 0, illegal instruction 2, virtual instruction 22.

Top module: `trapret_seq`

## Requirements
- R1: One cycle after a request, exactly one of `doneValid` and `trapValid` is high for that cycle. With no request, both are low and every state output, the return PC and the code hold their previous values. After reset, the privilege output is 3 and every other output is 0.
- R2: A machine return requested at a privilege other than 3 raises code 2.
- R3: A supervisor return requested at privilege 0 raises code 2.
- R4: When `compressedEn` is 0 and either of bits 1:0 of the selected saved PC is set, the return raises code 0. When `compressedEn` is 1, no alignment check is made and the PC is returned unchanged.
- R5: A supervisor return with `stTsr` set raises code 2 below privilege 3. At privilege 3 it completes.
- R6: A supervisor return raises code 22 when `hypPresent`, `curVirt` and `hsVtsr` are all 1.
- R7: When several checks fail at once, the code follows this order: privilege check (R2/R3) first, then alignment (R4), then the trap-supervisor-return bit (R5), then the virtual trap bit (R6).
- R8: A completed machine return sets the new privilege to the old saved machine-previous privilege. It copies the machine previous-enable bit into the machine enable bit, sets the machine previous-enable bit to 1, and clears the machine previous privilege to 0 and the machine previous-virtualization bit to 0. The return PC is the machine saved PC.
- R9: On a completed machine return with `hypPresent`=1, the new virtualization flag equals the old machine previous-virtualization bit, and `swapReq` is high exactly when that bit was 1. With `hypPresent`=0, the flag is unchanged and `swapReq` stays 0.
- R10: A completed supervisor return sets the new privilege to the old supervisor-previous bit (0 or 1). It copies the supervisor previous-enable bit into the supervisor enable bit, sets the supervisor previous-enable bit to 1, and clears the supervisor previous privilege. The return PC is the supervisor saved PC.
- R11: On a completed supervisor return with `hypPresent`=1 and `curVirt`=0, the hypervisor previous-virtualization bit is cleared, the new flag equals its old value, and `swapReq` equals its old value. In all other cases, that bit and the flag are unchanged and `swapReq` is 0.
- R12: When an exception is raised, every state output equals the corresponding current input, the return PC is 0 and `swapReq` is 0.
- R13: If both return requests are high in the same cycle, the block performs the machine return only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retMach | input | 1 | Machine return request |
| retSup | input | 1 | Supervisor return request |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| curVirt | input | 1 | Current virtualization flag |
| hypPresent | input | 1 | Hypervisor layer implemented |
| compressedEn | input | 1 | 16-bit instructions supported |
| stMie | input | 1 | Machine interrupt enable |
| stMpie | input | 1 | Machine previous interrupt enable |
| stMpp | input | 2 | Machine previous privilege |
| stMpv | input | 1 | Machine previous virtualization |
| stSie | input | 1 | Supervisor interrupt enable |
| stSpie | input | 1 | Supervisor previous interrupt enable |
| stSpp | input | 1 | Supervisor previous privilege |
| stTsr | input | 1 | Trap supervisor returns |
| hsSpv | input | 1 | Hypervisor-status previous virtualization |
| hsVtsr | input | 1 | Trap supervisor returns of a guest |
| mEpc | input | XLEN | Machine saved PC |
| sEpc | input | XLEN | Supervisor saved PC |
| doneValid | output | 1 | Return completed this cycle |
| trapValid | output | 1 | Return raised an exception this cycle |
| trapCode | output | 5 | Exception code (0 after a completed return) |
| nxtPriv | output | 2 | Next privilege |
| nxtVirt | output | 1 | Next virtualization flag |
| nxtMie | output | 1 | Next machine interrupt enable |
| nxtMpie | output | 1 | Next machine previous interrupt enable |
| nxtMpp | output | 2 | Next machine previous privilege |
| nxtMpv | output | 1 | Next machine previous virtualization |
| nxtSie | output | 1 | Next supervisor interrupt enable |
| nxtSpie | output | 1 | Next supervisor previous interrupt enable |
| nxtSpp | output | 1 | Next supervisor previous privilege |
| nxtSpv | output | 1 | Next hypervisor previous virtualization |
| retPc | output | XLEN | Return target PC (0 on exception) |
| swapReq | output | 1 | One-cycle request to swap guest register bank |

## Verification
Two groups of events can land in one cycle: several legality failures on the same request, and both return requests at once. The bench provokes the first by pairing a low privilege with a misaligned saved PC, and by setting both trap bits in a guest supervisor context. It provokes the second by raising both requests with distinct saved PCs. Each result is judged against a scoreboard entry that the bench derives from the priority order and the machine-wins rule. The exact code and return PC show which check or which operation took effect.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } privLvl_e;

  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    EXC_MISALIGN = 5'd0,
    EXC_ILLEGAL  = 5'd2,
    EXC_VIRTINSN = 5'd22
  } excCode_e;

  // strobes from legality control to the datapath
  typedef struct packed {
    logic     fire;     // a return is being processed this cycle
    logic     machSel;  // 1: machine return, 0: supervisor return
    logic     raise;    // return is refused
    excCode_e code;     // reason when refused
  } retStrobe_t;
endpackage

// File: rtl/trapret_ctrl.sv
module trapret_ctrl
  import trapret_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retMach,
  input  logic       retSup,
  input  logic [1:0] curPriv,
  input  logic       curVirt,
  input  logic       hypPresent,
  input  logic       compressedEn,
  input  logic       stTsr,
  input  logic       hsVtsr,
  input  logic [1:0] mEpcLow,
  input  logic [1:0] sEpcLow,
  output retStrobe_t strobe
);
  logic       machSel;
  logic [1:0] pcLow;
  logic       privBad, misalBad, tsrBad, vtsrBad;

  always_comb begin
    machSel  = retMach;                       // machine return has precedence
    pcLow    = machSel ? mEpcLow : sEpcLow;
    misalBad = !compressedEn && (pcLow != 2'b00);
    privBad  = machSel ? (curPriv != PRIV_M) : (curPriv == PRIV_U);
    tsrBad   = !machSel && stTsr && (curPriv != PRIV_M);
    vtsrBad  = !machSel && hypPresent && curVirt && hsVtsr;

    strobe.fire    = retMach | retSup;
    strobe.machSel = machSel;
    strobe.raise   = strobe.fire && (privBad || misalBad || tsrBad || vtsrBad);
    if (privBad)       strobe.code = EXC_ILLEGAL;
    else if (misalBad) strobe.code = EXC_MISALIGN;
    else if (tsrBad)   strobe.code = EXC_ILLEGAL;
    else if (vtsrBad)  strobe.code = EXC_VIRTINSN;
    else               strobe.code = EXC_MISALIGN;
  end

  // a supervisor return from supervisor level with the trap bit set is refused
  p_sret_tsr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (retSup && !retMach && curPriv == PRIV_S && stTsr) |-> strobe.raise)
    else $error("p_sret_tsr_r5");

  // the guest trap bit alone produces a virtual-instruction fault
  p_vtsr_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (retSup && !retMach && curPriv == PRIV_S && !stTsr && hypPresent && curVirt
     && hsVtsr && (compressedEn || sEpcLow == 2'b00))
    |-> (strobe.raise && strobe.code == EXC_VIRTINSN))
    else $error("p_vtsr_code_r6");
endmodule

// File: rtl/trapret_dpath.sv
module trapret_dpath
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  retStrobe_t        strobe,
  input  logic [1:0]        curPriv,
  input  logic              curVirt,
  input  logic              hypPresent,
  input  logic              stMie,
  input  logic              stMpie,
  input  logic [1:0]        stMpp,
  input  logic              stMpv,
  input  logic              stSie,
  input  logic              stSpie,
  input  logic              stSpp,
  input  logic              hsSpv,
  input  logic [XLEN-1:0]   mEpc,
  input  logic [XLEN-1:0]   sEpc,
  output logic              doneValid,
  output logic              trapValid,
  output logic [CODE_W-1:0] trapCode,
  output logic [1:0]        nxtPriv,
  output logic              nxtVirt,
  output logic              nxtMie,
  output logic              nxtMpie,
  output logic [1:0]        nxtMpp,
  output logic              nxtMpv,
  output logic              nxtSie,
  output logic              nxtSpie,
  output logic              nxtSpp,
  output logic              nxtSpv,
  output logic [XLEN-1:0]   retPc,
  output logic              swapReq
);
  logic [1:0]      cPriv, cMpp;
  logic            cVirt, cMie, cMpie, cMpv, cSie, cSpie, cSpp, cSpv, cSwap;
  logic [XLEN-1:0] cPc;

  // next-state values for a completed return
  always_comb begin
    cPriv = curPriv; cVirt = curVirt;
    cMie  = stMie;   cMpie = stMpie; cMpp = stMpp; cMpv = stMpv;
    cSie  = stSie;   cSpie = stSpie; cSpp = stSpp; cSpv = hsSpv;
    cSwap = 1'b0;
    if (strobe.machSel) begin
      cPriv = stMpp;
      cMie  = stMpie;
      cMpie = 1'b1;
      cMpp  = PRIV_U;
      cMpv  = 1'b0;
      cPc   = mEpc;
      if (hypPresent) begin
        cVirt = stMpv;
        cSwap = stMpv;
      end
    end else begin
      cPriv = {1'b0, stSpp};
      cSie  = stSpie;
      cSpie = 1'b1;
      cSpp  = 1'b0;
      cPc   = sEpc;
      if (hypPresent && !curVirt) begin
        cSpv  = 1'b0;
        cVirt = hsSpv;
        cSwap = hsSpv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0; trapValid <= 1'b0; trapCode <= '0;
      nxtPriv   <= PRIV_M; nxtVirt <= 1'b0;
      nxtMie    <= 1'b0; nxtMpie <= 1'b0; nxtMpp <= 2'b00; nxtMpv <= 1'b0;
      nxtSie    <= 1'b0; nxtSpie <= 1'b0; nxtSpp <= 1'b0; nxtSpv <= 1'b0;
      retPc     <= '0; swapReq <= 1'b0;
    end else if (strobe.fire) begin
      doneValid <= !strobe.raise;
      trapValid <= strobe.raise;
      if (strobe.raise) begin
        trapCode <= strobe.code;
        nxtPriv  <= curPriv; nxtVirt <= curVirt;
        nxtMie   <= stMie;   nxtMpie <= stMpie; nxtMpp <= stMpp; nxtMpv <= stMpv;
        nxtSie   <= stSie;   nxtSpie <= stSpie; nxtSpp <= stSpp; nxtSpv <= hsSpv;
        retPc    <= '0;
        swapReq  <= 1'b0;
      end else begin
        trapCode <= '0;
        nxtPriv  <= cPriv; nxtVirt <= cVirt;
        nxtMie   <= cMie;  nxtMpie <= cMpie; nxtMpp <= cMpp; nxtMpv <= cMpv;
        nxtSie   <= cSie;  nxtSpie <= cSpie; nxtSpp <= cSpp; nxtSpv <= cSpv;
        retPc    <= cPc;
        swapReq  <= cSwap;
      end
    end else begin
      doneValid <= 1'b0;
      trapValid <= 1'b0;
      swapReq   <= 1'b0;
    end
  end

  p_one_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && trapValid))
    else $error("p_one_result_r1");

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> (!doneValid && !trapValid && $stable(nxtPriv) && $stable(retPc)))
    else $error("p_idle_hold_r1");

  p_mret_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.machSel && !strobe.raise)
    |=> (nxtMpie && nxtMpp == 2'b00 && !nxtMpv))
    else $error("p_mret_fields_r8");

  p_swap_enters_guest_r9: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> (nxtVirt && doneValid))
    else $error("p_swap_enters_guest_r9");

  p_trap_keeps_priv_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.raise) |=> (nxtPriv == $past(curPriv) && !swapReq && retPc == '0))
    else $error("p_trap_keeps_priv_r12");
endmodule

// File: rtl/trapret_seq.sv
module trapret_seq
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retMach,
  input  logic              retSup,
  input  logic [1:0]        curPriv,
  input  logic              curVirt,
  input  logic              hypPresent,
  input  logic              compressedEn,
  input  logic              stMie,
  input  logic              stMpie,
  input  logic [1:0]        stMpp,
  input  logic              stMpv,
  input  logic              stSie,
  input  logic              stSpie,
  input  logic              stSpp,
  input  logic              stTsr,
  input  logic              hsSpv,
  input  logic              hsVtsr,
  input  logic [XLEN-1:0]   mEpc,
  input  logic [XLEN-1:0]   sEpc,
  output logic              doneValid,
  output logic              trapValid,
  output logic [4:0]        trapCode,
  output logic [1:0]        nxtPriv,
  output logic              nxtVirt,
  output logic              nxtMie,
  output logic              nxtMpie,
  output logic [1:0]        nxtMpp,
  output logic              nxtMpv,
  output logic              nxtSie,
  output logic              nxtSpie,
  output logic              nxtSpp,
  output logic              nxtSpv,
  output logic [XLEN-1:0]   retPc,
  output logic              swapReq
);
  retStrobe_t strobe;

  trapret_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .retMach(retMach), .retSup(retSup),
    .curPriv(curPriv), .curVirt(curVirt), .hypPresent(hypPresent),
    .compressedEn(compressedEn), .stTsr(stTsr), .hsVtsr(hsVtsr),
    .mEpcLow(mEpc[1:0]), .sEpcLow(sEpc[1:0]), .strobe(strobe)
  );

  trapret_dpath #(.XLEN(XLEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curPriv(curPriv), .curVirt(curVirt), .hypPresent(hypPresent),
    .stMie(stMie), .stMpie(stMpie), .stMpp(stMpp), .stMpv(stMpv),
    .stSie(stSie), .stSpie(stSpie), .stSpp(stSpp), .hsSpv(hsSpv),
    .mEpc(mEpc), .sEpc(sEpc),
    .doneValid(doneValid), .trapValid(trapValid), .trapCode(trapCode),
    .nxtPriv(nxtPriv), .nxtVirt(nxtVirt), .nxtMie(nxtMie), .nxtMpie(nxtMpie),
    .nxtMpp(nxtMpp), .nxtMpv(nxtMpv), .nxtSie(nxtSie), .nxtSpie(nxtSpie),
    .nxtSpp(nxtSpp), .nxtSpv(nxtSpv), .retPc(retPc), .swapReq(swapReq)
  );

  // both requests together: the supervisor saved PC must not be returned
  p_mach_wins_r13: assert property (@(posedge clk) disable iff (!rstN)
    (retMach && retSup && curPriv == 2'd3 && (compressedEn || mEpc[1:0] == 2'b00))
    |=> (doneValid && retPc == $past(mEpc)))
    else $error("p_mach_wins_r13");
endmodule

// File: tb/trapret_seq_test.sv
module trapret_seq_test;
  localparam int XLEN = 32;

  typedef struct packed {
    logic rm, rs; logic [1:0] priv; logic virt, hyp, cmp;
    logic mie, mpie; logic [1:0] mpp; logic mpv;
    logic sie, spie, spp, tsr, spv, vtsr;
    logic [XLEN-1:0] mepc, sepc;
  } stim_t;

  typedef struct packed {
    logic trap; logic [4:0] code; logic [1:0] priv; logic virt;
    logic mie, mpie; logic [1:0] mpp; logic mpv;
    logic sie, spie, spp, spv; logic [XLEN-1:0] pc; logic swap;
  } res_t;

  typedef struct { res_t v; string tag; } item_t;

  logic clk = 0, rstN = 0;
  stim_t s;
  logic doneValid, trapValid, nxtVirt, nxtMie, nxtMpie, nxtMpv;
  logic nxtSie, nxtSpie, nxtSpp, nxtSpv, swapReq;
  logic [4:0] trapCode; logic [1:0] nxtPriv, nxtMpp; logic [XLEN-1:0] retPc;

  item_t sbq[$];
  res_t  lastExp;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  trapret_seq #(.XLEN(XLEN)) uut (
    .clk(clk), .rstN(rstN), .retMach(s.rm), .retSup(s.rs), .curPriv(s.priv),
    .curVirt(s.virt), .hypPresent(s.hyp), .compressedEn(s.cmp),
    .stMie(s.mie), .stMpie(s.mpie), .stMpp(s.mpp), .stMpv(s.mpv),
    .stSie(s.sie), .stSpie(s.spie), .stSpp(s.spp), .stTsr(s.tsr),
    .hsSpv(s.spv), .hsVtsr(s.vtsr), .mEpc(s.mepc), .sEpc(s.sepc),
    .doneValid(doneValid), .trapValid(trapValid), .trapCode(trapCode),
    .nxtPriv(nxtPriv), .nxtVirt(nxtVirt), .nxtMie(nxtMie), .nxtMpie(nxtMpie),
    .nxtMpp(nxtMpp), .nxtMpv(nxtMpv), .nxtSie(nxtSie), .nxtSpie(nxtSpie),
    .nxtSpp(nxtSpp), .nxtSpv(nxtSpv), .retPc(retPc), .swapReq(swapReq)
  );

  function automatic res_t actual();
    res_t a;
    a = '{trapValid, trapCode, nxtPriv, nxtVirt, nxtMie, nxtMpie, nxtMpp, nxtMpv,
          nxtSie, nxtSpie, nxtSpp, nxtSpv, retPc, swapReq};
    return a;
  endfunction

  // expected result derived from the requirement list
  function automatic res_t model(stim_t t);
    res_t e;
    logic mach;
    logic [1:0] low;
    mach = t.rm;                                            // R13
    low  = mach ? t.mepc[1:0] : t.sepc[1:0];
    e = '{1'b0, 5'd0, t.priv, t.virt, t.mie, t.mpie, t.mpp, t.mpv,
          t.sie, t.spie, t.spp, t.spv, '0, 1'b0};           // R12 baseline
    if (mach ? (t.priv != 2'd3) : (t.priv == 2'd0)) begin e.trap = 1; e.code = 5'd2; end
    else if (!t.cmp && low != 2'b00)                begin e.trap = 1; e.code = 5'd0; end
    else if (!mach && t.tsr && t.priv != 2'd3)      begin e.trap = 1; e.code = 5'd2; end
    else if (!mach && t.hyp && t.virt && t.vtsr)    begin e.trap = 1; e.code = 5'd22; end
    if (e.trap) return e;
    if (mach) begin                                         // R8, R9
      e.priv = t.mpp; e.mie = t.mpie; e.mpie = 1; e.mpp = 0; e.mpv = 0; e.pc = t.mepc;
      if (t.hyp) begin e.virt = t.mpv; e.swap = t.mpv; end
    end else begin                                          // R10, R11
      e.priv = {1'b0, t.spp}; e.sie = t.spie; e.spie = 1; e.spp = 0; e.pc = t.sepc;
      if (t.hyp && !t.virt) begin e.spv = 0; e.virt = t.spv; e.swap = t.spv; end
    end
    return e;
  endfunction

  task automatic issue(stim_t t, string tag);
    item_t it;
    @(negedge clk);
    s = t;
    it.v = model(t); it.tag = tag;
    sbq.push_back(it);
    lastExp = it.v;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    s.rm = 0; s.rs = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, res_t act, res_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every produced result with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && (doneValid || trapValid)) begin
      res_t a;
      a = actual();
      if (sbq.size() == 0) begin
        check(0, "R1 unexpected result", a, '0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(a == it.v && (doneValid != trapValid), it.tag, a, it.v);
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    stim_t b;
    res_t rst;
    s = '0;
    repeat (3) @(negedge clk);
    rst = '0; rst.priv = 2'd3;
    check(actual() == rst && !doneValid, "R1 reset state", actual(), rst);
    rstN = 1;

    b = '0; b.cmp = 0; b.mepc = 32'h0000_1000; b.sepc = 32'h0000_2000;

    // machine return from machine level, back-to-back stream
    b.rm = 1; b.priv = 3; b.mpp = 1; b.mpie = 1; b.mie = 0; b.mpv = 0;
    issue(b, "R8 mret to supervisor");
    b.mpp = 0; b.mpie = 0; b.mie = 1;
    issue(b, "R8 mret to user");
    b.priv = 1; issue(b, "R2 mret from supervisor");
    b.priv = 0; issue(b, "R2 mret from user");
    b.priv = 3; b.mepc = 32'h0000_1002; issue(b, "R4 mret misaligned");
    b.cmp = 1; issue(b, "R4 mret halfword pc with compressed");
    b.cmp = 0; b.mepc = 32'h0000_1001; b.priv = 1; issue(b, "R7 privilege before alignment");
    b.mepc = 32'h0000_1000; b.priv = 3;
    b.hyp = 1; b.mpv = 1; b.mpp = 1; issue(b, "R9 mret into guest swaps");
    b.hyp = 0; b.virt = 0; issue(b, "R9 mret no hypervisor");
    b.hyp = 1; b.mpv = 0; b.virt = 1; issue(b, "R9 mret leaves guest");
    idle(3);
    check(!doneValid && !trapValid && actual().priv == lastExp.priv &&
          retPc == lastExp.pc && trapCode == lastExp.code, "R1 hold when idle", actual(), lastExp);

    // supervisor returns
    b = '0; b.rs = 1; b.mepc = 32'h0000_3000; b.sepc = 32'h0000_4000;
    b.priv = 1; b.spp = 0; b.spie = 1; b.sie = 0;
    issue(b, "R10 sret to user");
    b.spp = 1; b.spie = 0; b.sie = 1; issue(b, "R10 sret to supervisor");
    b.priv = 0; issue(b, "R3 sret from user");
    b.sepc = 32'h0000_4003; issue(b, "R7 user sret misaligned gives illegal");
    b.priv = 1; issue(b, "R4 sret misaligned");
    b.sepc = 32'h0000_4000; b.tsr = 1; issue(b, "R5 sret trapped by tsr");
    b.priv = 3; issue(b, "R5 sret from machine ignores tsr");
    b.priv = 1; b.tsr = 0; b.hyp = 1; b.virt = 1; b.vtsr = 1; b.spv = 1;
    issue(b, "R6 guest sret virtual fault");
    b.tsr = 1; issue(b, "R7 tsr before guest trap bit");
    b.tsr = 0; b.vtsr = 0; issue(b, "R11 guest sret keeps spv");
    b.virt = 0; issue(b, "R11 host sret enters guest");
    b.spv = 0; issue(b, "R11 host sret stays host");
    b.hyp = 0; b.spv = 1; issue(b, "R11 no hypervisor keeps spv");

    // both requests in the same cycle
    b = '0; b.rm = 1; b.rs = 1; b.priv = 3; b.mpp = 1; b.mpie = 1;
    b.spp = 1; b.spie = 1; b.mepc = 32'h0000_5000; b.sepc = 32'h0000_6000;
    issue(b, "R13 both requests machine wins");
    b.priv = 1; issue(b, "R13 both requests from supervisor trap");
    idle(4);

    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results actual=%0d expected=0", sbq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule